// File: doc/BRIEF.md
# Dual Prescaled Reload Timer

This block holds two independent 8-bit down-counters that share one register bus. Each counter has a reload value and a prescale setting. A common control register starts, stops and loads the counters. Each counter decrements once every `8 * (S + 1)` system clocks, where `S` is the 6-bit scale field of its prescale register. When a decrement brings the count to zero, the counter reloads from its reload value in that same cycle and raises its interrupt request. A per-timer repeat bit then decides whether the counter keeps running or stops after that one pass.

Software writes the reload and prescale registers while a timer is stopped. It then writes the control register with the load and enable bits of that timer. The live count can be read back at any time. Each interrupt request stays high until the matching acknowledge input is pulsed. Timer 1 counts only while its clock-select bit chooses the internal clock. No external clock source is provided, so with that bit clear the timer stays frozen.

Register addresses: 0 is control, 1 is the timer 0 reload register (write) and its count (read), 2 is the timer 0 prescale register, 3 is the timer 1 reload register (write) and its count (read), and 4 is the timer 1 prescale register. A write to any other address is ignored, and a read from any other address returns 0.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset: both counts and both reload values are 0, both timers are stopped, and both interrupt requests are low. The timer 0 repeat bit and both timer 1 bits [1:0] (repeat and clock select) are cleared.
- R2: Control register bits: bit 0 loads timer 0, bit 1 enables timer 0, bit 2 loads timer 1, bit 3 enables timer 1. A read of address 0 returns the running state of timer 0 in bit 1 and of timer 1 in bit 3; all other bits read 0.
- R3: A load copies the reload value into the counter and restarts the prescaler. With load and enable written together, the first decrement happens exactly `8*(S+1)` clocks after the write edge.
- R4: A running timer decrements by one every `8*(S+1)` clocks, where S is bits [7:2] of its prescale register.
- R5: A decrement that reaches zero instead reloads the counter from its reload value in that cycle and sets that timer's interrupt request (bit 0 for timer 0, bit 1 for timer 1).
- R6: After that reload, the timer keeps running if bit 0 (repeat) of its prescale register is 1. Otherwise it stops, its run bit reads 0, and the count holds the reload value.
- R7: Timer 1 advances only while bit 1 of its prescale register is 1 (internal clock). Timer 0 has no such bit.
- R8: Reads of addresses 1 and 3 return the live counts, never the reload value. Prescale addresses read 0.
- R9: An interrupt request stays high until an `irq_ack` pulse for that timer. If a terminal count and an acknowledge arrive in the same cycle, the request stays set.
- R10: A reload value of 0 gives 256 decrements per pass: the count wraps to 255 and the request appears after `256*8*(S+1)` clocks.
- R11: Writing the reload register of a running timer leaves its current count unchanged; the new value is used at the next reload.
- R12: Clearing an enable bit without a load freezes that count and its prescaler phase. Setting the bit again resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_ack | input | 2 | Per-timer acknowledge pulse |
| irq_req | output | 2 | Per-timer interrupt request |

## Verification
A register write takes effect at the clock edge on which `bus_wr` is sampled. Read data is combinational, so it shows the new state right after that edge. A loaded count therefore appears at the write edge, and its first decrement lands `8*(S+1)` edges later. Interrupt requests and reloads show up on the same edge as the terminal decrement. The bench keeps a behavioural model that advances on every rising edge and compares both requests and the addressed read data a quarter period later. The directed checks count whole cycles from the negative edge that follows each write, sampling just before and just after each expected decrement.

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int W       = 8,
  parameter int DIV_LOG = 3,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [1:0]    irq_ack,
  output logic [1:0]    irq_req
);
  localparam int PSW = W - 2;
  localparam int PCW = PSW + DIV_LOG;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_T0   = AW'(1);
  localparam logic [AW-1:0] A_P0   = AW'(2);
  localparam logic [AW-1:0] A_T1   = AW'(3);
  localparam logic [AW-1:0] A_P1   = AW'(4);

  logic [1:0][W-1:0] cnt_a, load_a;
  logic [1:0]        run_a, modn_a, irq_a;
  logic              clk1_int_q;

  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk1_int_q <= 1'b0;
    else if (bus_wr && bus_addr == A_P1) clk1_int_q <= bus_wdata[1];

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    localparam logic [AW-1:0] A_LD = (i == 0) ? A_T0 : A_T1;
    localparam logic [AW-1:0] A_PS = (i == 0) ? A_P0 : A_P1;

    logic [W-1:0]   cnt, ld;
    logic [PSW-1:0] scale;
    logic [PCW-1:0] ph;
    logic           run, modn, irq;

    wire src      = (i == 0) ? 1'b1 : clk1_int_q;
    wire load_hit = ctrl_wr && bus_wdata[2*i];
    wire adv      = run && src;
    wire at_lim   = (ph == {scale, {DIV_LOG{1'b1}}});
    wire tick     = adv && at_lim;
    wire term     = tick && (cnt == {{(W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk)
      if (bus_wr && bus_addr == A_PS) scale <= bus_wdata[W-1:2];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt  <= '0;
        ld   <= '0;
        ph   <= '0;
        run  <= 1'b0;
        modn <= 1'b0;
        irq  <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == A_LD) ld <= bus_wdata;
        if (bus_wr && bus_addr == A_PS) modn <= bus_wdata[0];
        if (load_hit) begin
          cnt <= ld;
          ph  <= '0;
        end else begin
          if (tick) cnt <= term ? ld : cnt - 1'b1;
          if (adv)  ph  <= at_lim ? '0 : ph + 1'b1;
        end
        if (ctrl_wr)            run <= bus_wdata[2*i+1];
        else if (term && !modn) run <= 1'b0;
        if (term)            irq <= 1'b1;
        else if (irq_ack[i]) irq <= 1'b0;
      end

    assign cnt_a[i]  = cnt;
    assign load_a[i] = ld;
    assign run_a[i]  = run;
    assign modn_a[i] = modn;
    assign irq_a[i]  = irq;
  end

  assign irq_req = irq_a;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {{(W-4){1'b0}}, run_a[1], 1'b0, run_a[0], 1'b0};
      A_T0:   bus_rdata = cnt_a[0];
      A_T1:   bus_rdata = cnt_a[1];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [1:0]      irq_ack,
  input logic [1:0]      irq_req,
  input logic [1:0][W-1:0] cnt_a,
  input logic [1:0][W-1:0] load_a,
  input logic [1:0]      run_a,
  input logic [1:0]      modn_a
);
  wire ctrl_wr = bus_wr && (bus_addr == AW'(0));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] && !irq_ack[i] |=> irq_req[i]); // R9
    AST_IRQ_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[i]) |-> $past(run_a[i]) && cnt_a[i] == $past(load_a[i])); // R5
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[i]) && !$past(modn_a[i]) && !$past(ctrl_wr) |-> !run_a[i]); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_a[i] && !ctrl_wr |=> $stable(cnt_a[i])); // R12
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      run_a[i] && !ctrl_wr |=> cnt_a[i] == $past(cnt_a[i]) ||
        cnt_a[i] == W'($past(cnt_a[i]) - 1'b1) ||
        (irq_req[i] && cnt_a[i] == $past(load_a[i]))); // R4
  end
endmodule

bind dual_reload_timer dual_reload_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .irq_ack(irq_ack), .irq_req(irq_req), .cnt_a(cnt_a), .load_a(load_a),
  .run_a(run_a), .modn_a(modn_a)
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] irq_ack = '0;
  logic [1:0] irq_req;

  int checks = 0, fails = 0;
  bit done = 0;

  dual_reload_timer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_cnt[2], m_load[2], m_scale[2], m_el[2], m_run[2], m_modn[2], m_irq[2];
  int m_src1;

  function automatic int m_read(int a);
    case (a)
      0: return m_run[1] * 8 + m_run[0] * 2;
      1: return m_cnt[0];
      3: return m_cnt[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_load[i] = 0; m_el[i] = 0; m_run[i] = 0;
        m_modn[i] = 0; m_irq[i] = 0;
      end
      m_src1 = 0;
    end else begin
      int reload_old[2];
      bit term[2];
      for (int i = 0; i < 2; i++) begin
        reload_old[i] = m_load[i];
        term[i] = 0;
        if (m_run[i] != 0 && (i == 0 || m_src1 != 0)) begin
          m_el[i]++;
          if (m_el[i] == 8 * (m_scale[i] + 1)) begin
            m_el[i] = 0;
            if (m_cnt[i] == 1) begin
              term[i] = 1;
              m_cnt[i] = reload_old[i];
            end else m_cnt[i] = (m_cnt[i] + 255) % 256;
          end
        end
        if (term[i]) begin
          m_irq[i] = 1;
          if (m_modn[i] == 0) m_run[i] = 0;
        end else if (irq_ack[i]) m_irq[i] = 0;
      end
      if (bus_wr) begin
        case (bus_addr)
          0: for (int i = 0; i < 2; i++) begin
               if (bus_wdata[2*i]) begin m_cnt[i] = reload_old[i]; m_el[i] = 0; end
               m_run[i] = bus_wdata[2*i+1];
             end
          1: m_load[0] = bus_wdata;
          2: begin m_scale[0] = bus_wdata[7:2]; m_modn[0] = bus_wdata[0]; end
          3: m_load[1] = bus_wdata;
          4: begin m_scale[1] = bus_wdata[7:2]; m_modn[1] = bus_wdata[0]; m_src1 = bus_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      checks++;
      if (irq_req != 2'(m_irq[1] * 2 + m_irq[0])) begin
        fails++;
        $display("FAIL R9 irq_req actual=%b expected=%b", irq_req, 2'(m_irq[1]*2 + m_irq[0]));
      end
      checks++;
      if (int'(bus_rdata) != m_read(int'(bus_addr))) begin
        fails++;
        $display("FAIL %s read addr %0d actual=%0d expected=%0d",
                 (bus_addr == 0) ? "R2" : "R8", bus_addr, bus_rdata, m_read(int'(bus_addr)));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(int a, output int v);
    bus_addr = 3'(a);
    #1 v = int'(bus_rdata);
  endtask

  task automatic ack(int i);
    @(negedge clk); irq_ack[i] = 1'b1;
    @(negedge clk); irq_ack[i] = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_now(0, v); chk("R1 ctrl", v, 0);
    rd_now(1, v); chk("R1 count0", v, 0);
    rd_now(3, v); chk("R1 count1", v, 0);
    chk("R1 irq", int'(irq_req), 0);

    // R3/R4/R5 continuous timer 0, S=1 -> 16 clocks per step
    wr(2, 8'h05);
    rd_now(2, v); chk("R8 prescale reads 0", v, 0);
    wr(1, 3);
    rd_now(1, v); chk("R8 reload not visible", v, 0);
    wr(0, 8'h03);
    rd_now(1, v); chk("R3 loaded", v, 3);
    repeat (15) @(negedge clk);
    rd_now(1, v); chk("R3 no early step", v, 3);
    @(negedge clk);
    rd_now(1, v); chk("R4 first step", v, 2);
    repeat (16) @(negedge clk);
    rd_now(1, v); chk("R4 second step", v, 1);
    chk("R5 no irq yet", int'(irq_req), 0);
    repeat (16) @(negedge clk);
    rd_now(1, v); chk("R5 reload", v, 3);
    chk("R5 irq0", int'(irq_req), 1);
    rd_now(0, v); chk("R6 repeat keeps running", v, 2);
    repeat (20) @(negedge clk);
    chk("R9 sticky", int'(irq_req[0]), 1);
    ack(0);
    chk("R9 cleared by ack", int'(irq_req[0]), 0);

    // R12 stop and resume
    wr(0, 8'h00);
    rd_now(1, v);
    repeat (40) @(negedge clk);
    rd_now(1, v2); chk("R12 frozen", v2, v);
    wr(0, 8'h02);
    repeat (70) @(negedge clk);
    wr(0, 8'h00);

    // R6 one-shot, S=0
    wr(2, 8'h00); wr(1, 2); wr(0, 8'h03);
    repeat (16) @(negedge clk);
    chk("R6 irq at terminal", int'(irq_req[0]), 1);
    rd_now(0, v); chk("R6 stopped", v, 0);
    repeat (30) @(negedge clk);
    rd_now(1, v); chk("R6 holds reload", v, 2);
    ack(0);

    // R11 reload write while running
    wr(2, 8'h01); wr(1, 4); wr(0, 8'h03);
    repeat (8) @(negedge clk);
    rd_now(1, v); chk("R11 step", v, 3);
    wr(1, 9);
    rd_now(1, v); chk("R11 count undisturbed", v, 3);
    repeat (22) @(negedge clk);
    rd_now(1, v); chk("R11 new reload used", v, 9);
    wr(0, 8'h00);
    ack(0);

    // R7 timer 1 clock select
    wr(4, 8'h00); wr(3, 5); wr(0, 8'h0C);
    repeat (40) @(negedge clk);
    rd_now(3, v); chk("R7 frozen without internal clock", v, 5);
    rd_now(0, v); chk("R2 run bit timer1", v, 8);
    wr(4, 8'h02);
    repeat (8) @(negedge clk);
    rd_now(3, v); chk("R7 counts with internal clock", v, 4);
    wr(0, 8'h00);

    // R10 reload 0 gives 256 steps
    wr(2, 8'h01); wr(1, 0); wr(0, 8'h03);
    repeat (8) @(negedge clk);
    rd_now(1, v); chk("R10 wrap to 255", v, 255);
    repeat (2039) @(negedge clk);
    rd_now(1, v); chk("R10 last count", v, 1);
    chk("R10 no irq before pass end", int'(irq_req[0]), 0);
    @(negedge clk);
    rd_now(1, v); chk("R10 reload to 0", v, 0);
    chk("R10 irq after 2048", int'(irq_req[0]), 1);
    wr(0, 8'h00);
    ack(0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule